// File: doc/BRIEF.md
# Mixed-Width Function-Unit Dependency Matrix

This block is the unit-to-unit wait table of a scoreboard in which the function units come in two width classes, 32-bit and 8-bit, held together in one square matrix. Each row belongs to a consumer unit, and each column to a producer unit. When an instruction issues to a unit, the issue logic supplies a vector naming the units whose results it still needs. The block stores that vector in the consumer's row, and each producer clears its column when it pulses completion. A unit may start its arithmetic only when its row is empty. Because both classes share one matrix, a 32-bit unit can wait on an 8-bit unit and the reverse.

A 64-bit operation runs on two neighbouring 32-bit units, with one half on each. Such a wide issue must name an even 32-bit unit as its lower half. The producer vector goes into the lower unit's row, and the upper unit's row is emptied. The two units are then ganged: each reports ready only when both rows are empty, so the ALU can collect operands from both at once. A wide issue aimed anywhere else is refused in the same cycle and changes nothing.

Unit ids run from 0 to `N_W32-1` for the 32-bit class, then continue with the 8-bit class.

Top module: `fu_dep_matrix`

## Requirements
- R1: While `rst_n` is low at a clock edge, every row and every gang flag is cleared, so after that edge `ready_o` is all ones and no unit is ganged.
- R2: A narrow accepted issue to unit i with producer bit j set (j not i, j not completing that cycle) sets cell (i,j), and `ready_o[i]` is low from the cycle after the issue edge.
- R3: A completion pulse `done_i[j]` clears column j in every row at that edge. A unit whose row becomes empty shows `ready_o` high in the following cycle.
- R4: When a producer bit j is issued in the same cycle as `done_i[j]`, the completion wins and the cell is not recorded.
- R5: A producer bit that names the issuing unit itself is ignored. For a wide issue, bits naming either member of the pair are ignored.
- R6: Dependencies cross width classes: a 32-bit unit can wait on an 8-bit unit, and an 8-bit unit can wait on a 32-bit unit.
- R7: A wide issue (`iss_wide`=1) to an even 32-bit unit k records the vector in row k, empties row k+1, and gangs the pair. Both `ready_o[k]` and `ready_o[k+1]` are then high only when rows k and k+1 are both empty.
- R8: A wide issue to an odd id, to an 8-bit unit, or to any id at or beyond the unit count raises `iss_rej_o` combinationally in that cycle. A rejected issue changes no row and no gang flag.
- R9: An accepted narrow issue to either member of a ganged pair dissolves the gang, so each member again reports only its own row.
- R10: An accepted issue replaces the target row's previous contents instead of merging with them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_vld | input | 1 | Issue event present this cycle |
| iss_fu | input | $clog2(N_W32+N_W8) | Target unit id (lower half when wide) |
| iss_wide | input | 1 | Issue is a 64-bit operation on a unit pair |
| iss_prod | input | N_W32+N_W8 | Producer units the issuing operation waits on |
| done_i | input | N_W32+N_W8 | Per-unit completion pulse |
| ready_o | output | N_W32+N_W8 | Per-unit ready-to-start |
| iss_rej_o | output | 1 | Current issue is refused |

## Verification
The assertions take `done_i` to be a single-cycle pulse that carries meaning on its own, with no handshake against the issue port. The hold check on a refused issue assumes that no completion arrives in the same cycle, because a completion could legitimately raise a ready bit. The stimulus drives every input on the falling edge and holds an issue for exactly one cycle. It keeps `done_i` at zero in the cycles where a refusal is being checked, and pairs issue with completion only in the scenario that tests which of the two wins.

// File: rtl/fdm_pkg.sv
// Shared definitions for the mixed-width dependency matrix.
// Assumes unit ids place all 32-bit units below all 8-bit units.
package fdm_pkg;
    typedef enum logic {
        CLS_W32 = 1'b0,
        CLS_W8  = 1'b1
    } fu_class_e;

    // Width class of a unit id, given the 32-bit unit count.
    function automatic fu_class_e fu_class(input int id, input int n_w32);
        return (id < n_w32) ? CLS_W32 : CLS_W8;
    endfunction
endpackage

// File: rtl/fdm_dep_row.sv
// One consumer row of the matrix: a bit per producer unit.
// Loads a masked producer vector on issue (or clears on wipe),
// otherwise drops the columns of completing producers.
// Assumes set_vec already has pair bits removed by the decoder.
module fdm_dep_row #(
    parameter int NUM_FU = 8,
    parameter int ROW    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              wipe,
    input  logic [NUM_FU-1:0] set_vec,
    input  logic [NUM_FU-1:0] done_i,
    output logic [NUM_FU-1:0] row_q
);
    localparam logic [NUM_FU-1:0] SELF = NUM_FU'(1) << ROW;

    // Row update: reset, reload on issue, else clear completed columns.
    always_ff @(posedge clk) begin
        if (!rst_n)
            row_q <= '0;
        else if (set_en)
            row_q <= wipe ? '0 : (set_vec & ~done_i & ~SELF);
        else
            row_q <= row_q & ~done_i;
    end

    // R3
    col_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|done_i) && !set_en) |=> ((row_q & $past(done_i)) == '0));

    // R4
    done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !wipe && ((set_vec & done_i) != '0))
            |=> ((row_q & $past(done_i)) == '0));
endmodule

// File: rtl/fdm_issue_dec.sv
// Decodes one issue event into per-row load strobes, the shared
// producer vector, gang set/clear strobes and the refusal flag.
// Assumes NUM_W32 is even; ids >= NUM_FU are refused.
module fdm_issue_dec
    import fdm_pkg::*;
#(
    parameter int NUM_W32 = 4,
    parameter int NUM_FU  = 8,
    parameter int IDW     = 3,
    parameter int NPAIR   = 2
) (
    input  logic              iss_vld,
    input  logic [IDW-1:0]    iss_fu,
    input  logic              iss_wide,
    input  logic [NUM_FU-1:0] iss_prod,
    output logic [NUM_FU-1:0] row_set,
    output logic [NUM_FU-1:0] row_wipe,
    output logic [NUM_FU-1:0] row_vec,
    output logic [NPAIR-1:0]  pair_set,
    output logic [NPAIR-1:0]  pair_clr,
    output logic              iss_rej
);
    int  fu_id;
    logic bad_id, bad_wide, acc;
    logic [NUM_FU-1:0] self_mask, hi_mask;

    // Refusal and acceptance of the current issue.
    always_comb begin
        fu_id    = int'(iss_fu);
        bad_id   = fu_id >= NUM_FU;
        bad_wide = iss_wide && (iss_fu[0] || fu_class(fu_id, NUM_W32) != CLS_W32);
        iss_rej  = iss_vld && (bad_id || bad_wide);
        acc      = iss_vld && !iss_rej;
    end

    // Producer vector with the target unit(s) masked out.
    always_comb begin
        self_mask = NUM_FU'(1) << iss_fu;
        hi_mask   = iss_wide ? (self_mask << 1) : '0;
        row_vec   = iss_prod & ~self_mask & ~hi_mask;
    end

    for (genvar i = 0; i < NUM_FU; i++) begin : g_rows
        // Row i loads when it is the target or the upper half of a wide target.
        always_comb begin
            row_wipe[i] = iss_wide && (fu_id + 1 == i);
            row_set[i]  = acc && ((fu_id == i) || row_wipe[i]);
        end
    end

    for (genvar k = 0; k < NPAIR; k++) begin : g_pairs
        // Gang strobes: wide issue to the lower unit sets, narrow to either clears.
        always_comb begin
            pair_set[k] = acc && iss_wide && (fu_id == 2 * k);
            pair_clr[k] = acc && !iss_wide && ((fu_id >> 1) == k);
        end
    end
endmodule

// File: rtl/fdm_pair_ctl.sv
// Holds one gang flag per even/odd pair of 32-bit units.
// Assumes set and clear strobes are never raised together.
module fdm_pair_ctl #(
    parameter int NPAIR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPAIR-1:0] pair_set,
    input  logic [NPAIR-1:0] pair_clr,
    output logic [NPAIR-1:0] pair_q
);
    // Gang flag update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pair_q <= '0;
        else
            pair_q <= (pair_q | pair_set) & ~pair_clr;
    end

    // R9
    gang_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pair_clr) |=> ((pair_q & $past(pair_clr)) == '0));

    // R7
    gang_make_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pair_set) |=> ((pair_q & $past(pair_set)) == $past(pair_set)));
endmodule

// File: rtl/fu_dep_matrix.sv
// Unit-to-unit dependency matrix for a scoreboard mixing 32-bit and
// 8-bit units, with 64-bit operations ganged on even/odd 32-bit pairs.
// Assumes done_i are single-cycle pulses and ids 0..N_W32-1 are 32-bit.
module fu_dep_matrix #(
    parameter int N_W32 = 4,
    parameter int N_W8  = 4,
    localparam int NUM_FU = N_W32 + N_W8,
    localparam int IDW    = $clog2(NUM_FU),
    localparam int NPAIR  = N_W32 / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_vld,
    input  logic [IDW-1:0]    iss_fu,
    input  logic              iss_wide,
    input  logic [NUM_FU-1:0] iss_prod,
    input  logic [NUM_FU-1:0] done_i,
    output logic [NUM_FU-1:0] ready_o,
    output logic              iss_rej_o
);
    logic [NUM_FU-1:0] row_set, row_wipe, row_vec;
    logic [NPAIR-1:0]  pair_set, pair_clr, pair_q;
    logic [NUM_FU-1:0] rows [NUM_FU];

    fdm_issue_dec #(
        .NUM_W32(N_W32), .NUM_FU(NUM_FU), .IDW(IDW), .NPAIR(NPAIR)
    ) u_dec (
        .iss_vld(iss_vld), .iss_fu(iss_fu), .iss_wide(iss_wide),
        .iss_prod(iss_prod), .row_set(row_set), .row_wipe(row_wipe),
        .row_vec(row_vec), .pair_set(pair_set), .pair_clr(pair_clr),
        .iss_rej(iss_rej_o)
    );

    fdm_pair_ctl #(.NPAIR(NPAIR)) u_pair (
        .clk(clk), .rst_n(rst_n), .pair_set(pair_set),
        .pair_clr(pair_clr), .pair_q(pair_q)
    );

    for (genvar i = 0; i < NUM_FU; i++) begin : g_row
        fdm_dep_row #(.NUM_FU(NUM_FU), .ROW(i)) u_row (
            .clk(clk), .rst_n(rst_n), .set_en(row_set[i]),
            .wipe(row_wipe[i]), .set_vec(row_vec), .done_i(done_i),
            .row_q(rows[i])
        );
        if (i < N_W32) begin : g_w32
            // Ready of a 32-bit unit: own row empty, and partner's too when ganged.
            assign ready_o[i] = ~|rows[i] & (~pair_q[i / 2] | ~|rows[i ^ 1]);
        end else begin : g_w8
            // Ready of an 8-bit unit: own row empty.
            assign ready_o[i] = ~|rows[i];
        end
    end

    logic [NUM_FU-1:0] need_mask;
    // Producers an issue still waits on after self and completion removal (for checks).
    always_comb need_mask = iss_prod & ~done_i & ~(NUM_FU'(1) << iss_fu);

    // R1
    reset_ready_chk: assert property (@(posedge clk)
        !rst_n |=> (ready_o == '1));

    // R2
    iss_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && !iss_rej_o && !iss_wide && (need_mask != '0))
            |=> !ready_o[$past(iss_fu)]);

    // R7
    wide_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && !iss_rej_o && iss_wide
            && ((need_mask & ~(NUM_FU'(2) << iss_fu)) != '0))
            |=> (!ready_o[$past(iss_fu)] && !ready_o[$past(iss_fu) + 1'b1]));

    // R8
    rej_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_rej_o && (done_i == '0)) |=> $stable(ready_o));
endmodule

// File: tb/sim_fu_dep_matrix.sv
module sim_fu_dep_matrix;
    localparam int NF = 8;
    logic clk = 1'b0, rst_n = 1'b0;
    logic iss_vld = 1'b0, iss_wide = 1'b0;
    logic [2:0] iss_fu = '0;
    logic [NF-1:0] iss_prod = '0, done_i = '0;
    logic [NF-1:0] ready_o;
    logic iss_rej_o;
    int n_chk = 0, n_bad = 0;
    logic last_rej;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    fu_dep_matrix u0 (
        .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_fu(iss_fu),
        .iss_wide(iss_wide), .iss_prod(iss_prod), .done_i(done_i),
        .ready_o(ready_o), .iss_rej_o(iss_rej_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle issue (optionally with completions); rejection flag captured mid-cycle.
    task automatic issue(input int fu, input bit wide, input logic [NF-1:0] prod,
                         input logic [NF-1:0] dn);
        @(negedge clk);
        iss_vld = 1'b1; iss_fu = 3'(fu); iss_wide = wide; iss_prod = prod; done_i = dn;
        #1 last_rej = iss_rej_o;
        @(negedge clk);
        iss_vld = 1'b0; iss_wide = 1'b0; iss_prod = '0; done_i = '0;
    endtask

    task automatic pulse(input logic [NF-1:0] dn);
        @(negedge clk); done_i = dn;
        @(negedge clk); done_i = '0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 ready after reset", ready_o, 8'hFF);
        chk("R1 no reject idle", iss_rej_o, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_basic;   // 32-bit unit 0 waits on 8-bit units 4,5
        issue(0, 0, 8'h30, 0);
        chk("R2 unit0 blocked", ready_o[0], 0);
        chk("R6 32-bit waits on 8-bit", ready_o, 8'hFE);
        pulse(8'h10);
        chk("R3 partial completion keeps block", ready_o[0], 0);
        pulse(8'h20);
        chk("R3 last completion frees unit0", ready_o[0], 1);
    endtask

    task automatic t_reverse; // 8-bit unit 5 waits on 32-bit unit 1
        issue(5, 0, 8'h02, 0);
        chk("R6 8-bit waits on 32-bit", ready_o[5], 0);
        pulse(8'h02);
        chk("R3 unit5 freed", ready_o[5], 1);
    endtask

    task automatic t_diag;
        issue(2, 0, 8'h04, 0);
        chk("R5 self bit ignored", ready_o[2], 1);
        issue(2, 0, 8'h0C, 0);
        chk("R5 other bit kept", ready_o[2], 0);
        pulse(8'h08);
        chk("R5 only non-self bit stored", ready_o[2], 1);
    endtask

    task automatic t_same;
        issue(3, 0, 8'h40, 8'h40);
        chk("R4 completion wins over issue", ready_o[3], 1);
    endtask

    task automatic t_overwrite;
        issue(0, 0, 8'h10, 0);
        chk("R10 set", ready_o[0], 0);
        issue(0, 0, 8'h00, 0);
        chk("R10 reissue replaces row", ready_o[0], 1);
    endtask

    task automatic t_wide;
        issue(1, 0, 8'h20, 0);          // upper unit holds an old dependency
        issue(0, 1, 8'h83, 0);          // bits 0,1 ignored, 7 kept; row1 wiped
        chk("R8 even 32-bit accepted", last_rej, 0);
        chk("R7 lower blocked", ready_o[0], 0);
        chk("R7 upper follows pair", ready_o[1], 0);
        chk("R5 pair bits ignored", ready_o[7:2], 6'h3F);
        pulse(8'h80);
        chk("R7 pair released together", ready_o[1:0], 2'b11);
    endtask

    task automatic t_reject;
        issue(1, 1, 8'h10, 0);
        chk("R8 odd id refused", last_rej, 1);
        chk("R8 no state change odd", ready_o, 8'hFF);
        issue(4, 1, 8'h01, 0);
        chk("R8 8-bit wide refused", last_rej, 1);
        chk("R8 no state change 8-bit", ready_o, 8'hFF);
        issue(4, 0, 8'h01, 0);
        chk("R8 narrow 8-bit accepted", last_rej, 0);
        pulse(8'h01);
    endtask

    task automatic t_ungang;
        issue(2, 1, 8'h20, 0);
        chk("R7 pair 2/3 upper blocked", ready_o[3], 0);
        issue(3, 0, 8'h00, 0);
        chk("R9 upper freed after narrow", ready_o[3], 1);
        chk("R9 lower still blocked", ready_o[2], 0);
        pulse(8'h20);
        chk("R9 lower freed", ready_o[2], 1);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_basic();
        t_reverse();
        t_diag();
        t_same();
        t_overwrite();
        t_wide();
        t_reject();
        t_ungang();
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end
endmodule